// File: doc/BRIEF.md
# Single-Outstanding Register Access Adapter

This block sits between a host command port and a strobe-based register-access port. The host offers a command with a valid/ready handshake. The command carries a read-or-write flag, a byte address, write data and, optionally, byte enables. The adapter accepts the command only when it is idle and stores it in holding registers. It then raises one request line, together with either a read enable or a write enable.

Reads and writes use separate address buses on the register side. The write data and byte enables appear only for writes. All request outputs stay frozen until the acknowledge of the matching kind arrives. That acknowledge may come in the first request cycle or any number of cycles later. On that acknowledge the adapter drops the request and sends the host a one-cycle response. The response carries the read data and an error flag, both sampled at the acknowledge.

Only one transfer is ever in flight. The parameter `HAS_BE` selects whether the host supplies byte enables or whether they are tied to all ones.

Top module: `reg_access_adapter`

## Requirements
- R1: While reset is held and in the cycle after it is released, `h_ready` is 1. In the same period `ia_req`, `ia_wr_en`, `ia_rd_en` and `h_rsp_valid` are 0, and `ia_wr_addr`, `ia_rd_addr`, `ia_wr_data` and `ia_wr_be` are zero.
- R2: A command is accepted on a clock edge where `h_valid` and `h_ready` are both 1. `ia_req` is 1 in the cycle after that edge.
- R3: A write (`h_write`=1) drives `ia_wr_en`=1 and `ia_rd_en`=0. The write address, write data and byte enables equal the host values. `ia_rd_addr` is zero.
- R4: A read (`h_write`=0) drives `ia_rd_en`=1 and `ia_wr_en`=0. `ia_rd_addr` equals the host address. `ia_wr_addr`, `ia_wr_data` and `ia_wr_be` are zero.
- R5: From issue until the matching acknowledge, `ia_req`, both enables, both addresses, the write data and the byte enables do not change.
- R6: A matching acknowledge (`ia_rd_ack` for a read, `ia_wr_ack` for a write) completes the transfer in a cycle where `ia_req` is 1. This holds when it arrives in the first request cycle or later. In the next cycle `ia_req` is 0, `h_ready` is 1 and `h_rsp_valid` is 1 for exactly one cycle.
- R7: A read response carries `h_rsp_rdata` and `h_rsp_err` equal to `ia_rd_data` and `ia_rd_err` in the acknowledge cycle.
- R8: A write response carries `h_rsp_err` equal to `ia_wr_err` in the acknowledge cycle, with `h_rsp_rdata` zero.
- R9: Some acknowledges are ignored: those of the other kind during a transfer, and any acknowledge while idle. Such an acknowledge neither ends the request nor produces a response.
- R10: With `HAS_BE`=0, `ia_wr_be` is all ones during every write and `h_be` has no effect.
- R11: `h_ready` is 0 while a request is outstanding, so a second request is never issued before the first is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_valid | input | 1 | Host command valid |
| h_ready | output | 1 | Adapter idle and able to take a command |
| h_write | input | 1 | 1 = write command, 0 = read command |
| h_addr | input | ADDR_W | Byte address of the command |
| h_wdata | input | DATA_W | Write data |
| h_be | input | DATA_W/8 | Byte enables from the host (used only if HAS_BE=1) |
| h_rsp_valid | output | 1 | One-cycle response strobe |
| h_rsp_rdata | output | DATA_W | Read data of the response (zero for writes) |
| h_rsp_err | output | 1 | Error flag of the response |
| ia_req | output | 1 | Register-side request |
| ia_wr_en | output | 1 | Write enable |
| ia_rd_en | output | 1 | Read enable |
| ia_wr_addr | output | ADDR_W | Write byte address |
| ia_rd_addr | output | ADDR_W | Read byte address |
| ia_wr_data | output | DATA_W | Write data |
| ia_wr_be | output | DATA_W/8 | Write byte enables |
| ia_rd_ack | input | 1 | Read acknowledge strobe |
| ia_rd_err | input | 1 | Read error, valid with ia_rd_ack |
| ia_rd_data | input | DATA_W | Read data, valid with ia_rd_ack |
| ia_wr_ack | input | 1 | Write acknowledge strobe |
| ia_wr_err | input | 1 | Write error, valid with ia_wr_ack |

## Verification
Each request output is registered once, so it is due in the cycle right after the accepting edge. The response is registered once, so it is due in the cycle right after the acknowledge edge. It is gone again one cycle later.

The bench drives inputs and samples outputs on the falling edge. It checks the request in the first cycle after acceptance and again in every waiting cycle, against a snapshot of the host command. It checks the response exactly one and two cycles after the acknowledge edge.

The sweep covers acknowledge latencies of 0 to 3 cycles, both directions and both error values. Acknowledges of the wrong kind and acknowledges while idle are injected. A second instance with host byte enables disabled runs alongside.

// File: rtl/reg_adapter_pkg.sv
package reg_adapter_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } adp_state_e;

  // completion happens only on the acknowledge of the outstanding kind
  function automatic logic ack_matches(input logic is_write,
                                       input logic rd_ack,
                                       input logic wr_ack);
    return is_write ? wr_ack : rd_ack;
  endfunction

endpackage

// File: rtl/adp_cmd_hold.sv
module adp_cmd_hold #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter bit HAS_BE = 1'b1,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              h_write,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [BE_W-1:0]   h_be,
  output logic              cap_write,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_wdata,
  output logic [BE_W-1:0]   cap_be
);

  logic [BE_W-1:0] be_src;

  generate
    if (HAS_BE) begin : g_host_be
      assign be_src = h_be;
    end else begin : g_fill_be
      assign be_src = '1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_write <= 1'b0;
      cap_addr  <= '0;
      cap_wdata <= '0;
      cap_be    <= '0;
    end else if (load) begin
      cap_write <= h_write;
      cap_addr  <= h_addr;
      cap_wdata <= h_wdata;
      cap_be    <= be_src;
    end
  end

endmodule

// File: rtl/adp_seq.sv
module adp_seq
  import reg_adapter_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic h_valid,
  input  logic cap_write,
  input  logic ia_rd_ack,
  input  logic ia_wr_ack,
  output logic h_ready,
  output logic load,
  output logic busy,
  output logic ack_hit
);

  adp_state_e state_q, state_d;

  assign h_ready = (state_q == ST_IDLE);
  assign busy    = (state_q == ST_WAIT);
  assign load    = h_valid && h_ready;
  assign ack_hit = busy && ack_matches(cap_write, ia_rd_ack, ia_wr_ack);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load)    state_d = ST_WAIT;
      ST_WAIT: if (ack_hit) state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/adp_rsp.sv
module adp_rsp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_hit,
  input  logic              cap_write,
  input  logic [DATA_W-1:0] ia_rd_data,
  input  logic              ia_rd_err,
  input  logic              ia_wr_err,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= ack_hit;
      if (ack_hit) begin
        rsp_rdata <= cap_write ? '0 : ia_rd_data;
        rsp_err   <= cap_write ? ia_wr_err : ia_rd_err;
      end
    end
  end

endmodule

// File: rtl/reg_access_adapter.sv
module reg_access_adapter #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter bit HAS_BE = 1'b1,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [BE_W-1:0]   h_be,
  output logic              h_rsp_valid,
  output logic [DATA_W-1:0] h_rsp_rdata,
  output logic              h_rsp_err,
  output logic              ia_req,
  output logic              ia_wr_en,
  output logic              ia_rd_en,
  output logic [ADDR_W-1:0] ia_wr_addr,
  output logic [ADDR_W-1:0] ia_rd_addr,
  output logic [DATA_W-1:0] ia_wr_data,
  output logic [BE_W-1:0]   ia_wr_be,
  input  logic              ia_rd_ack,
  input  logic              ia_rd_err,
  input  logic [DATA_W-1:0] ia_rd_data,
  input  logic              ia_wr_ack,
  input  logic              ia_wr_err
);

  logic              load, busy, ack_hit;
  logic              cap_write;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_wdata;
  logic [BE_W-1:0]   cap_be;
  logic              wr_live, rd_live;

  adp_cmd_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_BE(HAS_BE)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load),
    .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata), .h_be(h_be),
    .cap_write(cap_write), .cap_addr(cap_addr), .cap_wdata(cap_wdata), .cap_be(cap_be)
  );

  adp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .cap_write(cap_write),
    .ia_rd_ack(ia_rd_ack), .ia_wr_ack(ia_wr_ack),
    .h_ready(h_ready), .load(load), .busy(busy), .ack_hit(ack_hit)
  );

  adp_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .ack_hit(ack_hit), .cap_write(cap_write),
    .ia_rd_data(ia_rd_data), .ia_rd_err(ia_rd_err), .ia_wr_err(ia_wr_err),
    .rsp_valid(h_rsp_valid), .rsp_rdata(h_rsp_rdata), .rsp_err(h_rsp_err)
  );

  // each path is live only while its kind of transfer is outstanding
  assign wr_live    = busy && cap_write;
  assign rd_live    = busy && !cap_write;
  assign ia_req     = busy;
  assign ia_wr_en   = wr_live;
  assign ia_rd_en   = rd_live;
  assign ia_wr_addr = wr_live ? cap_addr  : '0;
  assign ia_rd_addr = rd_live ? cap_addr  : '0;
  assign ia_wr_data = wr_live ? cap_wdata : '0;
  assign ia_wr_be   = wr_live ? cap_be    : '0;

endmodule

// File: rtl/reg_adapter_chk.sv
module reg_adapter_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_ready,
  input logic              h_rsp_valid,
  input logic              ia_req,
  input logic              ia_wr_en,
  input logic              ia_rd_en,
  input logic [ADDR_W-1:0] ia_wr_addr,
  input logic [ADDR_W-1:0] ia_rd_addr,
  input logic [DATA_W-1:0] ia_wr_data,
  input logic [BE_W-1:0]   ia_wr_be,
  input logic              ia_rd_ack,
  input logic              ia_wr_ack
);

  logic ack_seen;
  assign ack_seen = ia_req && ((ia_wr_en && ia_wr_ack) || (ia_rd_en && ia_rd_ack));

  AST_IDLE_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ia_req |-> !ia_wr_en && !ia_rd_en); // R1
  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ia_req |-> (ia_wr_en ^ ia_rd_en)); // R3
  AST_RD_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ia_rd_en |-> ia_rd_addr == '0); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ia_req && !ack_seen |=> ia_req && $stable(ia_wr_en) && $stable(ia_rd_en) &&
      $stable(ia_wr_addr) && $stable(ia_rd_addr) && $stable(ia_wr_data) &&
      $stable(ia_wr_be)); // R5
  AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_seen |=> h_rsp_valid && !ia_req && h_ready); // R6
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    h_rsp_valid |=> !h_rsp_valid); // R6
  AST_RSP_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    h_rsp_valid |-> $past(ack_seen)); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ia_req |-> !h_ready); // R11

endmodule

bind reg_access_adapter reg_adapter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_ready(h_ready), .h_rsp_valid(h_rsp_valid),
  .ia_req(ia_req), .ia_wr_en(ia_wr_en), .ia_rd_en(ia_rd_en),
  .ia_wr_addr(ia_wr_addr), .ia_rd_addr(ia_rd_addr), .ia_wr_data(ia_wr_data),
  .ia_wr_be(ia_wr_be), .ia_rd_ack(ia_rd_ack), .ia_wr_ack(ia_wr_ack)
);

// File: tb/tb_reg_access_adapter.sv
`timescale 1ns/1ps
module tb_reg_access_adapter;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic h_valid = 0, h_write = 0;
  logic [AW-1:0] h_addr = '0;
  logic [DW-1:0] h_wdata = '0;
  logic [BW-1:0] h_be = '0;
  logic ia_rd_ack = 0, ia_rd_err = 0, ia_wr_ack = 0, ia_wr_err = 0;
  logic [DW-1:0] ia_rd_data = '0;

  logic h_ready, h_rsp_valid, h_rsp_err, ia_req, ia_wr_en, ia_rd_en;
  logic [DW-1:0] h_rsp_rdata, ia_wr_data;
  logic [AW-1:0] ia_wr_addr, ia_rd_addr;
  logic [BW-1:0] ia_wr_be;

  logic n_ready, n_rsp_valid, n_rsp_err, n_req, n_wr_en, n_rd_en;
  logic [DW-1:0] n_rsp_rdata, n_wr_data;
  logic [AW-1:0] n_wr_addr, n_rd_addr;
  logic [BW-1:0] n_wr_be;

  reg_access_adapter #(.ADDR_W(AW), .DATA_W(DW), .HAS_BE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
    .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata), .h_be(h_be),
    .h_rsp_valid(h_rsp_valid), .h_rsp_rdata(h_rsp_rdata), .h_rsp_err(h_rsp_err),
    .ia_req(ia_req), .ia_wr_en(ia_wr_en), .ia_rd_en(ia_rd_en),
    .ia_wr_addr(ia_wr_addr), .ia_rd_addr(ia_rd_addr), .ia_wr_data(ia_wr_data),
    .ia_wr_be(ia_wr_be), .ia_rd_ack(ia_rd_ack), .ia_rd_err(ia_rd_err),
    .ia_rd_data(ia_rd_data), .ia_wr_ack(ia_wr_ack), .ia_wr_err(ia_wr_err));

  reg_access_adapter #(.ADDR_W(AW), .DATA_W(DW), .HAS_BE(1'b0)) dut_nobe (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(n_ready),
    .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata), .h_be(h_be),
    .h_rsp_valid(n_rsp_valid), .h_rsp_rdata(n_rsp_rdata), .h_rsp_err(n_rsp_err),
    .ia_req(n_req), .ia_wr_en(n_wr_en), .ia_rd_en(n_rd_en),
    .ia_wr_addr(n_wr_addr), .ia_rd_addr(n_rd_addr), .ia_wr_data(n_wr_data),
    .ia_wr_be(n_wr_be), .ia_rd_ack(ia_rd_ack), .ia_rd_err(ia_rd_err),
    .ia_rd_data(ia_rd_data), .ia_wr_ack(ia_wr_ack), .ia_wr_err(ia_wr_err));

  int total = 0, bad = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] req_vec();
    return {ia_req, ia_wr_en, ia_rd_en, ia_wr_addr, ia_rd_addr, ia_wr_data[15:0], ia_wr_be};
  endfunction

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [BW-1:0] be, input int lat, input bit err,
                      input logic [DW-1:0] rdat);
    logic [63:0] snap;
    h_valid = 1; h_write = wr; h_addr = a; h_wdata = d; h_be = be;
    chk(h_ready == 1'b1, "R2 ready before accept", h_ready, 1);
    @(posedge clk); @(negedge clk);
    h_valid = 0; h_addr = ~a; h_wdata = ~d; h_be = ~be;
    chk(ia_req == 1'b1, "R2 req after accept", ia_req, 1);
    chk(h_ready == 1'b0, "R11 not ready while busy", h_ready, 0);
    if (wr) begin
      chk({ia_wr_en, ia_rd_en} == 2'b10, "R3 enables", {ia_wr_en, ia_rd_en}, 2'b10);
      chk(ia_wr_addr == a && ia_rd_addr == '0, "R3 addresses", {ia_wr_addr, ia_rd_addr}, {a, 8'h0});
      chk(ia_wr_data == d && ia_wr_be == be, "R3 data/be", {ia_wr_data, ia_wr_be}, {d, be});
      chk(n_wr_be == '1, "R10 filled byte enables", n_wr_be, 4'hF);
    end else begin
      chk({ia_wr_en, ia_rd_en} == 2'b01, "R4 enables", {ia_wr_en, ia_rd_en}, 2'b01);
      chk(ia_rd_addr == a && ia_wr_addr == '0, "R4 addresses", {ia_rd_addr, ia_wr_addr}, {a, 8'h0});
      chk(ia_wr_data == '0 && ia_wr_be == '0, "R4 write side quiet", {ia_wr_data, ia_wr_be}, 0);
    end
    snap = req_vec();
    for (int i = 0; i < lat; i++) begin
      // wrong-kind acknowledge must be ignored
      ia_rd_ack = wr; ia_wr_ack = !wr; ia_rd_data = 32'hDEAD0000 + i;
      @(posedge clk); @(negedge clk);
      ia_rd_ack = 0; ia_wr_ack = 0;
      chk(req_vec() == snap, "R5 request held", req_vec(), snap);
      chk(h_rsp_valid == 1'b0, "R9 no response on wrong ack", h_rsp_valid, 0);
    end
    if (wr) begin ia_wr_ack = 1; ia_wr_err = err; end
    else begin ia_rd_ack = 1; ia_rd_err = err; ia_rd_data = rdat; end
    @(posedge clk); @(negedge clk);
    ia_wr_ack = 0; ia_rd_ack = 0; ia_wr_err = !err; ia_rd_err = !err; ia_rd_data = ~rdat;
    chk(h_rsp_valid == 1'b1 && ia_req == 1'b0 && h_ready == 1'b1, "R6 completion",
        {h_rsp_valid, ia_req, h_ready}, 3'b101);
    if (wr)
      chk(h_rsp_err == err && h_rsp_rdata == '0, "R8 write response",
          {h_rsp_err, h_rsp_rdata}, {err, 32'h0});
    else
      chk(h_rsp_err == err && h_rsp_rdata == rdat, "R7 read response",
          {h_rsp_err, h_rsp_rdata}, {err, rdat});
    @(posedge clk); @(negedge clk);
    chk(h_rsp_valid == 1'b0, "R6 response one cycle", h_rsp_valid, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(h_ready && !ia_req && !ia_wr_en && !ia_rd_en && !h_rsp_valid, "R1 reset outputs",
        {h_ready, ia_req, ia_wr_en, ia_rd_en, h_rsp_valid}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    chk(ia_wr_addr == '0 && ia_rd_addr == '0 && ia_wr_data == '0 && ia_wr_be == '0,
        "R1 idle buses zero", {ia_wr_addr, ia_rd_addr, ia_wr_data[15:0], ia_wr_be}, 0);
    // acknowledges while idle
    ia_rd_ack = 1; ia_wr_ack = 1;
    @(posedge clk); @(negedge clk);
    ia_rd_ack = 0; ia_wr_ack = 0;
    @(posedge clk); @(negedge clk);
    chk(h_rsp_valid == 1'b0 && ia_req == 1'b0, "R9 idle ack ignored", {h_rsp_valid, ia_req}, 0);
    for (int lat = 0; lat < 4; lat++)
      for (int wr = 0; wr < 2; wr++)
        for (int e = 0; e < 2; e++) begin
          int k = lat * 4 + wr * 2 + e;
          xfer(wr[0], AW'(8'h11 * k + 3), 32'hA5000000 ^ (32'h01010101 * k),
               BW'(k % 16), lat, e[0], 32'h3C000000 + 32'h00010001 * k);
        end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule